// File: doc/BRIEF.md
# Depth-First Lattice Search Detector

This block finds the hard-decision symbol vector of a real-valued MIMO link. It works from an upper-triangular channel factor and a rotated receive vector, both held in a small register store. It walks the detection tree from the top level down and expands exactly one node in each clock cycle of the search. Each level of the tree is one real dimension, so a configuration with `NT` complex streams has `2*NT` levels. Every node has `SQM` children, which are the odd integers from `-(SQM-1)` to `SQM-1`. At a level, the children are tried in order of rising distance from that level's centre, alternating to either side of the nearest point. A search radius starts unbounded and shrinks to the metric of each better complete path that the search finds.

The host loads the matrix and the vector through a valid/ready write stream. It then pulses `start`, with the mode and the node budget set up beforehand. The result comes back on a valid/ready output. Each output holds the best vector found, its metric, a flag that says whether any complete path was found, and a flag that says whether the budget cut the search short. Two metric rules are available. One accumulates squared per-level errors. The other keeps the largest absolute per-level error, which is a max-norm approximation.

Top module: `sphere_dfs_core`

## Requirements
- R1: Write stream: a word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, and it is low during a search and while a result is waiting. Column index `in_col` equal to `2*NT` writes the receive entry of row `in_row`. A column below the row writes nothing. Words that are offered while `in_ready` is low have no effect.
- R2: Output packing: the symbol of level k sits in `out_sym[k*SW +: SW]` as a two's-complement odd integer within ±(SQM-1), where level 0 is the bottom of the tree.
- R3: With `max_mode`=0 and an unlimited budget, `out_metric` equals the minimum over all candidate vectors of the sum over levels of e_k², where e_k = y_k − Σ_{j>k} R_kj·s_j − R_kk·s_k. The returned vector achieves that minimum.
- R4: With `max_mode`=1 and an unlimited budget, `out_metric` equals the minimum over all vectors of the largest |e_k|, and the returned vector achieves that minimum.
- R5: The first dive picks, at every level, the point nearest to the centre; on an exact midpoint the lower point is taken. It reaches a leaf after exactly `2*NT` expansions, so a budget of `2*NT` returns that greedy path with `out_found`=1 and `out_early`=1.
- R6: `budget`=0 means no limit. When the count of expansions reaches a nonzero budget, the search stops with `out_early`=1. A search that ends with no complete path gives `out_found`=0 and an all-ones `out_metric`. A search that completes normally gives `out_early`=0.
- R7: `out_valid` stays high, with the symbols and the metric unchanged, until `out_ready` is sampled high. `done` is high for exactly the first cycle in which `out_valid` is high.
- R8: A `start` pulse has no effect unless the block is idle. The result of the search in progress is not changed by it.
- R9: After reset, `out_valid`=0, `done`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Write word can be taken (idle) |
| in_row | input | LW | Row index of the word |
| in_col | input | CW | Column index; 2*NT selects the receive entry |
| in_data | input | W | Signed value of the word |
| start | input | 1 | Begin a search (honoured only when idle) |
| max_mode | input | 1 | 1 selects the max-norm metric |
| budget | input | NBW | Expansion limit, 0 for none |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_sym | output | 2*NT*SW | Detected symbols, level 0 in the low bits |
| out_metric | output | MW | Metric of the detected vector |
| out_found | output | 1 | A complete path was found |
| out_early | output | 1 | The budget ended the search |
| done | output | 1 | One-cycle pulse when a result appears |

## Verification
If a frontier pointer at some level is stale or wrong, siblings get skipped or visited twice. That shows up in the same job as an `out_metric` above the exhaustive minimum, or as a returned vector whose recomputed metric does not match `out_metric`. If the radius or a stacked partial metric is corrupted, pruning goes wrong and the result of that job is non-minimal. It can also come out as a false `out_found`=0. Faults in the greedy first dive or in the budget counter show at once when a result is made after exactly `2*NT` or two expansions. A fault in the handshake shows within one cycle as a moving `out_sym` or a missing `done`.

// File: rtl/sdfs_pkg.sv
package sdfs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } sdfs_state_e;

  // Odd-integer symbol value for constellation index idx out of sqm points.
  function automatic int sdfs_sym(input int idx, input int sqm);
    return 2 * idx - sqm + 1;
  endfunction

endpackage

// File: rtl/sdfs_store.sv
module sdfs_store #(
  parameter int LEVELS = 4,
  parameter int W      = 8,
  localparam int LW    = $clog2(LEVELS),
  localparam int CW    = $clog2(LEVELS + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [LW-1:0]                         wr_row,
  input  logic [CW-1:0]                         wr_col,
  input  logic [W-1:0]                          wr_data,
  output logic [LEVELS-1:0][LEVELS-1:0][W-1:0]  r_o,
  output logic [LEVELS-1:0][W-1:0]              y_o
);

  for (genvar gr = 0; gr < LEVELS; gr++) begin : g_row
    logic [W-1:0] yq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) yq <= '0;
      else if (wr_en && wr_row == LW'(gr) && wr_col == CW'(LEVELS)) yq <= wr_data;
    end
    assign y_o[gr] = yq;

    for (genvar gc = 0; gc < LEVELS; gc++) begin : g_col
      if (gc >= gr) begin : g_keep
        logic [W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) cell_q <= '0;
          else if (wr_en && wr_row == LW'(gr) && wr_col == CW'(gc)) cell_q <= wr_data;
        end
        assign r_o[gr][gc] = cell_q;
      end else begin : g_zero
        assign r_o[gr][gc] = '0;
      end
    end
  end

endmodule

// File: rtl/sdfs_enum.sv
module sdfs_enum #(
  parameter int SQM  = 4,
  parameter int W    = 8,
  parameter int BW   = 14,
  parameter int EW   = 15,
  localparam int IW  = $clog2(SQM),
  localparam int SW  = IW + 1
) (
  input  logic signed [BW-1:0] b_i,
  input  logic signed [W-1:0]  rdiag_i,
  input  logic                 fresh_i,
  input  logic [IW-1:0]        lo_i,
  input  logic [IW-1:0]        hi_i,
  output logic                 has_o,
  output logic [IW-1:0]        pick_o,
  output logic [IW-1:0]        lo_o,
  output logic [IW-1:0]        hi_o
);

  function automatic logic signed [SW-1:0] sym_at(input logic [IW-1:0] i);
    return SW'(sdfs_pkg::sdfs_sym(int'(i), SQM));
  endfunction

  function automatic logic [EW-1:0] dist_at(input logic [IW-1:0] i);
    logic signed [EW-1:0] e;
    e = EW'(b_i) - EW'(rdiag_i) * EW'(sym_at(i));
    return (e < 0) ? EW'(-e) : EW'(e);
  endfunction

  logic [IW-1:0]        near_idx;
  logic signed [BW-1:0] thr;
  logic                 lo_ok, hi_ok;
  logic [EW-1:0]        dl, dh;

  // Nearest point without division: count midpoints r*(2j-SQM) below b.
  always_comb begin
    near_idx = '0;
    thr      = '0;
    for (int j = 1; j < SQM; j++) begin
      thr = BW'(rdiag_i) * BW'(2 * j - SQM);
      if (b_i > thr) near_idx = near_idx + IW'(1);
    end
  end

  assign lo_ok = (lo_i != '0);
  assign hi_ok = (hi_i != IW'(SQM - 1));
  assign dl    = dist_at(lo_i - IW'(1));
  assign dh    = dist_at(hi_i + IW'(1));

  always_comb begin
    has_o  = 1'b1;
    pick_o = near_idx;
    lo_o   = near_idx;
    hi_o   = near_idx;
    if (!fresh_i) begin
      lo_o = lo_i;
      hi_o = hi_i;
      if (lo_ok && (!hi_ok || dl <= dh)) begin
        pick_o = lo_i - IW'(1);
        lo_o   = lo_i - IW'(1);
      end else if (hi_ok) begin
        pick_o = hi_i + IW'(1);
        hi_o   = hi_i + IW'(1);
      end else begin
        has_o  = 1'b0;
        pick_o = lo_i;
      end
    end
  end

endmodule

// File: rtl/sdfs_metric.sv
module sdfs_metric #(
  parameter int LEVELS = 4,
  parameter int SQM    = 4,
  parameter int W      = 8,
  parameter int BW     = 14,
  parameter int EW     = 15,
  parameter int MW     = 33,
  localparam int IW    = $clog2(SQM),
  localparam int SW    = IW + 1,
  localparam int LW    = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0][LEVELS-1:0][W-1:0] r_i,
  input  logic [LEVELS-1:0][W-1:0]             y_i,
  input  logic [LEVELS-1:0][IW-1:0]            path_i,
  input  logic [LW-1:0]                        lvl_i,
  input  logic [IW-1:0]                        cand_i,
  input  logic [MW-1:0]                        tprev_i,
  input  logic                                 max_mode_i,
  output logic signed [BW-1:0]                 b_o,
  output logic signed [W-1:0]                  rdiag_o,
  output logic [MW-1:0]                        tnew_o
);

  function automatic logic signed [SW-1:0] sym_at(input logic [IW-1:0] i);
    return SW'(sdfs_pkg::sdfs_sym(int'(i), SQM));
  endfunction

  logic signed [BW-1:0] acc;
  logic signed [EW-1:0] e;
  logic [EW-1:0]        mag;
  logic [2*EW-1:0]      sq;

  // Interference from the symbols already fixed above this level.
  always_comb begin
    acc = BW'($signed(y_i[lvl_i]));
    for (int j = 0; j < LEVELS; j++) begin
      if (j > int'(lvl_i))
        acc = acc - BW'($signed(r_i[lvl_i][j])) * BW'(sym_at(path_i[j]));
    end
  end

  assign b_o     = acc;
  assign rdiag_o = $signed(r_i[lvl_i][lvl_i]);
  assign e       = EW'(acc) - EW'(rdiag_o) * EW'(sym_at(cand_i));
  assign mag     = (e < 0) ? EW'(-e) : EW'(e);
  assign sq      = (2*EW)'(mag) * (2*EW)'(mag);

  always_comb begin
    if (max_mode_i) tnew_o = (tprev_i > MW'(mag)) ? tprev_i : MW'(mag);
    else            tnew_o = tprev_i + MW'(sq);
  end

endmodule

// File: rtl/sphere_dfs_core.sv
module sphere_dfs_core #(
  parameter int NT   = 2,
  parameter int SQM  = 4,
  parameter int W    = 8,
  parameter int NBW  = 16,
  localparam int LEVELS = 2 * NT,
  localparam int LW  = $clog2(LEVELS),
  localparam int CW  = $clog2(LEVELS + 1),
  localparam int IW  = $clog2(SQM),
  localparam int SW  = IW + 1,
  localparam int BW  = W + SW + $clog2(LEVELS) + 1,
  localparam int EW  = BW + 1,
  localparam int MW  = 2 * EW + $clog2(LEVELS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LW-1:0]        in_row,
  input  logic [CW-1:0]        in_col,
  input  logic [W-1:0]         in_data,
  input  logic                 start,
  input  logic                 max_mode,
  input  logic [NBW-1:0]       budget,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LEVELS*SW-1:0] out_sym,
  output logic [MW-1:0]        out_metric,
  output logic                 out_found,
  output logic                 out_early,
  output logic                 done
);

  import sdfs_pkg::*;

  localparam logic [LW-1:0] TOP = LW'(LEVELS - 1);

  sdfs_state_e st;
  logic [LW-1:0]               lvl;
  logic                        fresh;
  logic [LEVELS-1:0][IW-1:0]   path, lo_q, hi_q, best;
  logic [LEVELS-1:0][MW-1:0]   tabove;
  logic [MW-1:0]               radius;
  logic                        found_q, early_q, mode_q, done_q;
  logic [NBW-1:0]              budget_q, cnt;

  logic [LEVELS-1:0][LEVELS-1:0][W-1:0] rmat;
  logic [LEVELS-1:0][W-1:0]             yvec;
  logic signed [BW-1:0] bval;
  logic signed [W-1:0]  rdiag;
  logic [MW-1:0]        tnew;
  logic                 has;
  logic [IW-1:0]        pick, lo_n, hi_n;

  logic at_top, at_leaf, hit, prune, go_up, take_leaf, finish;

  assign in_ready = (st == ST_IDLE);

  sdfs_store #(.LEVELS(LEVELS), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid && in_ready),
    .wr_row(in_row), .wr_col(in_col), .wr_data(in_data),
    .r_o(rmat), .y_o(yvec)
  );

  sdfs_metric #(.LEVELS(LEVELS), .SQM(SQM), .W(W), .BW(BW), .EW(EW), .MW(MW)) u_metric (
    .r_i(rmat), .y_i(yvec), .path_i(path), .lvl_i(lvl), .cand_i(pick),
    .tprev_i(tabove[lvl]), .max_mode_i(mode_q),
    .b_o(bval), .rdiag_o(rdiag), .tnew_o(tnew)
  );

  sdfs_enum #(.SQM(SQM), .W(W), .BW(BW), .EW(EW)) u_enum (
    .b_i(bval), .rdiag_i(rdiag), .fresh_i(fresh), .lo_i(lo_q[lvl]), .hi_i(hi_q[lvl]),
    .has_o(has), .pick_o(pick), .lo_o(lo_n), .hi_o(hi_n)
  );

  // Step decision for the current level.
  always_comb begin
    at_top    = (lvl == TOP);
    at_leaf   = (lvl == '0);
    hit       = has && (budget_q != '0) && (cnt + NBW'(1) == budget_q);
    prune     = has && (tnew >= radius);
    go_up     = !has || prune || at_leaf;
    take_leaf = has && !prune && at_leaf;
    finish    = (go_up && at_top) || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lvl      <= '0;
      fresh    <= 1'b0;
      path     <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      best     <= '0;
      tabove   <= '0;
      radius   <= '1;
      found_q  <= 1'b0;
      early_q  <= 1'b0;
      mode_q   <= 1'b0;
      budget_q <= '0;
      cnt      <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st       <= ST_RUN;
            lvl      <= TOP;
            fresh    <= 1'b1;
            tabove   <= '0;
            radius   <= '1;
            found_q  <= 1'b0;
            early_q  <= 1'b0;
            cnt      <= '0;
            mode_q   <= max_mode;
            budget_q <= budget;
          end
        end
        ST_RUN: begin
          if (has) begin
            if (cnt != '1) cnt <= cnt + NBW'(1);
            path[lvl] <= pick;
            lo_q[lvl] <= lo_n;
            hi_q[lvl] <= hi_n;
          end
          if (take_leaf) begin
            radius  <= tnew;
            found_q <= 1'b1;
            best    <= path;
            best[0] <= pick;
          end
          if (finish) begin
            st      <= ST_HOLD;
            done_q  <= 1'b1;
            early_q <= hit;
          end else if (go_up) begin
            lvl   <= lvl + LW'(1);
            fresh <= 1'b0;
          end else begin
            lvl                  <= lvl - LW'(1);
            fresh                <= 1'b1;
            tabove[lvl - LW'(1)] <= tnew;
          end
        end
        ST_HOLD: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < LEVELS; k++) begin : g_sym
    assign out_sym[k*SW +: SW] = SW'(sdfs_sym(int'(best[k]), SQM));
  end

  assign out_valid  = (st == ST_HOLD);
  assign out_metric = radius;
  assign out_found  = found_q;
  assign out_early  = early_q;
  assign done       = done_q;

endmodule

// File: rtl/sphere_dfs_core_chk.sv
module sphere_dfs_core_chk #(
  parameter int LEVELS = 4,
  parameter int SW     = 3,
  parameter int MW     = 33
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [LEVELS*SW-1:0] out_sym,
  input logic [MW-1:0]        out_metric,
  input logic                 out_found,
  input logic                 done
);

  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_metric));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_marks_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  // R7
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  // R6
  none_found_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_found |-> (&out_metric));

  for (genvar k = 0; k < LEVELS; k++) begin : g_odd
    // R2
    sym_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_sym[k*SW]);
  end

endmodule

bind sphere_dfs_core sphere_dfs_core_chk #(.LEVELS(LEVELS), .SW(SW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sym(out_sym), .out_metric(out_metric),
  .out_found(out_found), .done(done)
);

// File: tb/sphere_dfs_core_bench.sv
module sphere_dfs_core_bench;

  localparam int NT     = 2;
  localparam int SQM    = 4;
  localparam int W      = 8;
  localparam int NBW    = 16;
  localparam int LEVELS = 2 * NT;
  localparam int LW     = $clog2(LEVELS);
  localparam int CW     = $clog2(LEVELS + 1);
  localparam int IW     = $clog2(SQM);
  localparam int SW     = IW + 1;
  localparam int BW     = W + SW + $clog2(LEVELS) + 1;
  localparam int EW     = BW + 1;
  localparam int MW     = 2 * EW + $clog2(LEVELS) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LW-1:0] in_row = '0;
  logic [CW-1:0] in_col = '0;
  logic [W-1:0]  in_data = '0;
  logic start = 1'b0;
  logic max_mode = 1'b0;
  logic [NBW-1:0] budget = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [LEVELS*SW-1:0] out_sym;
  logic [MW-1:0] out_metric;
  logic out_found, out_early, done;

  always #2 clk = ~clk;

  sphere_dfs_core #(.NT(NT), .SQM(SQM), .W(W), .NBW(NBW)) u_sphere_dfs_core (.*);

  typedef struct {
    longint metric;
    bit     found;
    bit     early;
    bit     mx;
    string  req;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ended = 0;
  int   rm[LEVELS][LEVELS];
  int   yv[LEVELS];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint vec_metric(input int s[LEVELS], input bit mx);
    longint t = 0;
    for (int k = LEVELS - 1; k >= 0; k--) begin
      longint b = yv[k];
      longint e;
      for (int j = k + 1; j < LEVELS; j++) b -= longint'(rm[k][j]) * s[j];
      e = b - longint'(rm[k][k]) * s[k];
      if (e < 0) e = -e;
      if (mx) t = (e > t) ? e : t;
      else    t += e * e;
    end
    return t;
  endfunction

  function automatic longint brute(input bit mx);
    longint bestm = -1;
    int s[LEVELS];
    for (int c = 0; c < SQM ** LEVELS; c++) begin
      longint m;
      for (int k = 0; k < LEVELS; k++) s[k] = 2 * ((c / (SQM ** k)) % SQM) - SQM + 1;
      m = vec_metric(s, mx);
      if (bestm < 0 || m < bestm) bestm = m;
    end
    return bestm;
  endfunction

  function automatic longint greedy(input bit mx);
    int s[LEVELS];
    for (int k = 0; k < LEVELS; k++) s[k] = 0;
    for (int k = LEVELS - 1; k >= 0; k--) begin
      longint b = yv[k];
      longint bd = -1;
      for (int j = k + 1; j < LEVELS; j++) b -= longint'(rm[k][j]) * s[j];
      for (int i = 0; i < SQM; i++) begin
        longint d = b - longint'(rm[k][k]) * (2 * i - SQM + 1);
        if (d < 0) d = -d;
        if (bd < 0 || d < bd) begin
          bd = d;
          s[k] = 2 * i - SQM + 1;
        end
      end
    end
    return vec_metric(s, mx);
  endfunction

  // kind: 0 exhaustive optimum, 1 greedy first dive, 2 no leaf reached
  task automatic run_case(input bit mx, input int bud, input int kind, input bit disturb);
    exp_t x;
    for (int r = 0; r < LEVELS; r++) begin
      yv[r] = int'($urandom_range(200, 0)) - 100;
      for (int c = 0; c < LEVELS; c++) begin
        if (c == r)     rm[r][c] = int'($urandom_range(40, 1));
        else if (c > r) rm[r][c] = int'($urandom_range(80, 0)) - 40;
        else            rm[r][c] = 0;
      end
    end
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready idle", longint'(in_ready), 1);
    for (int r = 0; r < LEVELS; r++) begin
      for (int c = 0; c <= LEVELS; c++) begin
        in_valid = 1'b1;
        in_row   = LW'(r);
        in_col   = CW'(c);
        if (c == LEVELS) in_data = W'(yv[r]);
        else if (c < r)  in_data = W'(int'($urandom_range(255, 0)));
        else             in_data = W'(rm[r][c]);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    x.mx = mx;
    if (kind == 0) begin
      x.metric = brute(mx); x.found = 1; x.early = 0; x.req = mx ? "R4" : "R3";
    end else if (kind == 1) begin
      x.metric = greedy(mx); x.found = 1; x.early = 1; x.req = "R5";
    end else begin
      x.metric = -1; x.found = 0; x.early = 1; x.req = "R6";
    end
    sbq.push_back(x);
    max_mode = mx;
    budget   = NBW'(bud);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(in_ready == 1'b0, "R1", "in_ready busy", longint'(in_ready), 0);
    if (disturb) begin
      // R8: ignored start, and R1: ignored write while busy
      @(negedge clk);
      start    = 1'b1;
      max_mode = ~mx;
      in_valid = 1'b1;
      in_row   = LW'(LEVELS - 1);
      in_col   = CW'(LEVELS);
      in_data  = W'(yv[LEVELS-1] + 37);
      @(negedge clk);
      start    = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
    end
    while (!in_ready) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    int stall = 0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        exp_t x;
        logic [LEVELS*SW-1:0] held;
        int s[LEVELS];
        bit odd_ok = 1;
        check(done == 1'b1, "R7", "done at first valid", longint'(done), 1);
        if (sbq.size() == 0) begin
          check(0, "R7", "unexpected result", 1, 0);
        end else begin
          x = sbq.pop_front();
          check(out_found == x.found, "R6", "out_found", longint'(out_found), longint'(x.found));
          check(out_early == x.early, "R6", "out_early", longint'(out_early), longint'(x.early));
          if (x.found) begin
            check(longint'(out_metric) == x.metric, x.req, "out_metric",
                  longint'(out_metric), x.metric);
            for (int k = 0; k < LEVELS; k++) begin
              s[k] = $signed(out_sym[k*SW +: SW]);
              if ((s[k] % 2) == 0 || s[k] > SQM - 1 || s[k] < -(SQM - 1)) odd_ok = 0;
            end
            check(odd_ok, "R2", "symbol alphabet", longint'(out_sym), 0);
            check(vec_metric(s, x.mx) == longint'(out_metric), x.req, "vector metric",
                  vec_metric(s, x.mx), longint'(out_metric));
          end else begin
            check(&out_metric, "R6", "metric all ones", longint'(out_metric), -1);
          end
        end
        held = out_sym;
        stall++;
        for (int i = 0; i < 1 + (stall % 3); i++) begin
          @(negedge clk);
          check(out_valid && out_sym == held && !done, "R7", "hold under back-pressure",
                longint'(out_sym), longint'(held));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(out_valid == 1'b0, "R7", "release after ready", longint'(out_valid), 0);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && done == 1'b0, "R9", "outputs in reset",
          longint'({out_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
    check(done == 1'b0, "R9", "done after reset", longint'(done), 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);
    for (int i = 0; i < 12; i++) run_case(1'b0, 0, 0, 1'b0);     // R3
    for (int i = 0; i < 12; i++) run_case(1'b1, 0, 0, 1'b0);     // R4
    for (int i = 0; i < 3; i++)  run_case(1'b0, LEVELS, 1, 1'b0); // R5
    for (int i = 0; i < 3; i++)  run_case(1'b1, LEVELS, 1, 1'b0); // R5
    run_case(1'b0, 2, 2, 1'b0);                                  // R6
    run_case(1'b1, 1, 2, 1'b0);                                  // R6
    run_case(1'b0, 5000, 0, 1'b0);                               // R6 large budget
    run_case(1'b0, 0, 0, 1'b1);                                  // R8
    run_case(1'b1, 0, 0, 1'b1);                                  // R8
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R7", "all results returned", sbq.size(), 0);
    finish_run();
  end

endmodule